// File: doc/BRIEF.md
# Slot-Masked Serial Audio Transmitter

This block sends audio words from an internal transmit FIFO onto a single serial data line, one word per slot. Slots are grouped into frames of a programmable number of words. The bit clock is made by dividing the system clock. Each frame opens with one bit period of frame sync, with the data line low. After it come the slots, each a programmable number of bits long, most significant bit first. A per-slot mask silences chosen slots: the line stays low and no FIFO word is consumed.

When an unmasked slot finds the FIFO empty, the block raises a sticky underrun flag and the slot goes out as zeros. Two recovery policies follow. In continue mode the block remembers the slot position where the underrun happened. It then resumes at that same position in a later frame, the first one whose FIFO is non-empty when that slot comes round. Until then every slot is quiet, whatever masked slots come before it. In halt mode the block stays quiet until software clears the flag, and restarts at slot 0 of the frame after the one in which the flag was seen clear. A soft reset input flushes the FIFO, clears the flag and returns the sequencer to idle.

The sequencer has three states:
- S_IDLE moves to S_SYNC on the first enabled cycle.
- S_SYNC moves to S_SHIFT at the end of the sync bit.
- S_SHIFT loops through bits and slots, and returns to S_SYNC after the last bit of the last slot.
- Any state returns to S_IDLE when the block is disabled or in soft reset.

A second register holds the flow mode:
- M_RUN moves to M_RECOVER on an underrun in continue mode, or to M_HALT on an underrun otherwise.
- M_RECOVER moves back to M_RUN when the remembered slot pops a word.
- M_HALT moves to M_RUN at a frame end with the flag clear.

Top module: `slot_audio_tx`

## Requirements
- R1: `bclk` has a period of 2*(`bclk_div`+1) clock cycles, low for the first half of each bit period and high for the second. It stays low whenever `tx_en` is 0.
- R2: After `tx_en` is dropped and raised again with `bclk_div` above zero, the first rising edge of `bclk` comes `bclk_div`+1 cycles after enable, and the period is correct from then on.
- R3: Each frame is one bit period with `fsync`=1 and `sdata`=0, followed by `frame_len_m1`+1 slots of `word_len_m1`+1 bits each. `fsync` is 0 during all slot bits.
- R4: A slot sends bits [`word_len_m1`:0] of its FIFO word, most significant first. Upper bits are ignored. The receiver samples data on the rising edge of `bclk`.
- R5: Each unmasked slot whose mode permits sending pops exactly one FIFO word, in push order.
- R6: Slot s (slot 0 comes first after sync) is masked when `slot_mask[s]` is 1. A masked slot drives `sdata` low and pops nothing.
- R7: An unmasked slot that finds the FIFO empty sets `err_flag` and sends zeros. The flag holds until an `err_clr` pulse; a new underrun in the same cycle as the pulse wins.
- R8: With `cont_on_err`=1, all slots after an underrun at slot s send zeros without popping. From the next frame on, the block resumes at slot s of the first frame in which the FIFO is non-empty at that slot.
- R9: Recovery in R8 works when masked slots precede the underrun slot. Once the FIFO keeps up and the flag is cleared, it stays clear.
- R10: With `cont_on_err`=0, no word is popped after an underrun until the flag is cleared. Sending restarts at slot 0 of the frame after the first frame end seen with the flag clear.
- R11: While `soft_rst` is 1, the FIFO is flushed, `err_flag` is cleared and the sequencer is idle. On release, operation restarts cleanly with a new sync bit.
- R12: The FIFO holds `FIFO_DEPTH` words. `fifo_full` is 1 when it is full, and pushes while full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Soft reset, held while 1 |
| tx_en | input | 1 | Enables bit clock and sequencer |
| bclk_div | input | DIV_W | Half bit period minus one, in clock cycles |
| word_len_m1 | input | $clog2(DATA_W) | Bits per slot minus one |
| frame_len_m1 | input | $clog2(SLOTS) | Slots per frame minus one |
| slot_mask | input | SLOTS | Bit s silences slot s |
| cont_on_err | input | 1 | 1 selects continue mode, 0 selects halt mode |
| err_clr | input | 1 | Pulse that clears the underrun flag |
| wr_valid | input | 1 | Push a word into the FIFO |
| wr_data | input | DATA_W | Word to push |
| fifo_full | output | 1 | FIFO full |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, high for one bit period |
| sdata | output | 1 | Serial data |
| err_flag | output | 1 | Sticky underrun flag |

## Verification
Directed frames with a full FIFO and no mask check the bit order, the word framing and the ordered popping against a frame-level model. A sparse mask shows that masked slots neither drive data nor consume words. A case with the low slots masked, an underrun in a later slot and staged refills separates correct position-based recovery from one that counts only unmasked words. A halt case separates restart at slot 0 from restart at the failing slot. Randomized frame sizes, word lengths, dividers, masks, policies, preload counts, refill counts and flag clears hit underruns at varied positions. Every case first toggles the enable with a nonzero divider to check that the bit clock restarts correctly.

// File: rtl/slot_tx_pkg.sv
package slot_tx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SYNC  = 2'd1,
        S_SHIFT = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        M_RUN     = 2'd0,
        M_RECOVER = 2'd1,
        M_HALT    = 2'd2
    } flow_mode_t;
endpackage

// File: rtl/bclk_divider.sv
module bclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             bit_end
);
    logic [DIV_W-1:0] cnt;
    logic             phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == div) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign bclk    = phase;
    assign bit_end = en && phase && (cnt == div);

    // R1: the bit clock is low in any cycle following a disabled one
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !bclk);
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_full_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> full);
endmodule

// File: rtl/slot_audio_tx.sv
module slot_audio_tx
    import slot_tx_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SLOTS      = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       tx_en,
    input  logic [DIV_W-1:0]           bclk_div,
    input  logic [$clog2(DATA_W)-1:0]  word_len_m1,
    input  logic [$clog2(SLOTS)-1:0]   frame_len_m1,
    input  logic [SLOTS-1:0]           slot_mask,
    input  logic                       cont_on_err,
    input  logic                       err_clr,
    input  logic                       wr_valid,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       fifo_full,
    output logic                       bclk,
    output logic                       fsync,
    output logic                       sdata,
    output logic                       err_flag
);
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int SLOT_W = $clog2(SLOTS);

    seq_state_t        state;
    flow_mode_t        mode, mode_nxt;
    logic [SLOT_W-1:0] slot_q, err_slot, errslot_nxt, nxt_slot;
    logic [LEN_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg, fifo_dout, aligned;
    logic              en, bit_end, fifo_empty, fifo_pop, err_set;
    logic              last_bit, start_slot, frame_end;

    assign en = tx_en && !soft_rst;

    bclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(en), .div(bclk_div),
        .bclk(bclk), .bit_end(bit_end)
    );

    tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .push(wr_valid),
        .pop(fifo_pop), .din(wr_data), .dout(fifo_dout),
        .empty(fifo_empty), .full(fifo_full)
    );

    assign last_bit   = (bit_q == word_len_m1);
    assign nxt_slot   = (state == S_SYNC) ? '0 : SLOT_W'(slot_q + 1'b1);
    assign start_slot = bit_end && ((state == S_SYNC) ||
                        (state == S_SHIFT && last_bit && slot_q != frame_len_m1));
    assign frame_end  = bit_end && state == S_SHIFT && last_bit && slot_q == frame_len_m1;
    assign aligned    = fifo_dout << (LEN_W'(DATA_W - 1) - word_len_m1);

    // slot-start decision and flow-mode transitions
    always_comb begin
        fifo_pop    = 1'b0;
        err_set     = 1'b0;
        mode_nxt    = mode;
        errslot_nxt = err_slot;
        if (start_slot && !slot_mask[nxt_slot]) begin
            unique case (mode)
                M_RUN: begin
                    if (!fifo_empty) begin
                        fifo_pop = 1'b1;
                    end else begin
                        err_set     = 1'b1;
                        errslot_nxt = nxt_slot;
                        mode_nxt    = cont_on_err ? M_RECOVER : M_HALT;
                    end
                end
                M_RECOVER: begin
                    if (nxt_slot == err_slot) begin
                        if (!fifo_empty) begin
                            fifo_pop = 1'b1;
                            mode_nxt = M_RUN;
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (frame_end && mode == M_HALT && !err_flag) mode_nxt = M_RUN;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            mode     <= M_RUN;
            slot_q   <= '0;
            bit_q    <= '0;
            err_slot <= '0;
        end else if (!en) begin
            state    <= S_IDLE;
            mode     <= M_RUN;
            slot_q   <= '0;
            bit_q    <= '0;
            err_slot <= '0;
        end else begin
            mode     <= mode_nxt;
            err_slot <= errslot_nxt;
            unique case (state)
                S_IDLE: state <= S_SYNC;
                S_SYNC: if (bit_end) begin
                    state  <= S_SHIFT;
                    slot_q <= '0;
                    bit_q  <= '0;
                end
                S_SHIFT: if (bit_end) begin
                    if (last_bit) begin
                        bit_q <= '0;
                        if (slot_q == frame_len_m1) state <= S_SYNC;
                        else slot_q <= nxt_slot;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            fsync    <= 1'b0;
            sdata    <= 1'b0;
            shreg    <= '0;
        end else begin
            if (soft_rst) err_flag <= 1'b0;
            else          err_flag <= err_set || (err_flag && !err_clr);
            if (!en) begin
                fsync <= 1'b0;
                sdata <= 1'b0;
                shreg <= '0;
            end else if (state == S_IDLE || frame_end) begin
                fsync <= 1'b1;
                sdata <= 1'b0;
                shreg <= '0;
            end else if (start_slot) begin
                fsync <= 1'b0;
                sdata <= fifo_pop ? aligned[DATA_W-1] : 1'b0;
                shreg <= fifo_pop ? (aligned << 1) : '0;
            end else if (bit_end) begin
                sdata <= shreg[DATA_W-1];
                shreg <= shreg << 1;
            end
        end
    end

    p_sync_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> state == S_SYNC);
    p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_slot && slot_mask[nxt_slot] |=> !sdata);
    p_err_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(fifo_empty));
    p_resume_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_RECOVER && fifo_pop && en |=> mode == M_RUN);
    p_halt_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_HALT |-> !fifo_pop);
    p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> !err_flag && state == S_IDLE && fifo_empty);
endmodule

// File: tb/sim_slot_audio_tx.sv
`timescale 1ns/1ps
module sim_slot_audio_tx;
    localparam int DW = 16, NS = 8, FD = 8, DVW = 8;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, tx_en = 1'b0;
    logic cont_on_err = 1'b0, err_clr = 1'b0, wr_valid = 1'b0;
    logic [DVW-1:0] bclk_div = 8'd1;
    logic [3:0]  word_len_m1 = 4'd15;
    logic [2:0]  frame_len_m1 = 3'd0;
    logic [7:0]  slot_mask = 8'd0;
    logic [15:0] wr_data = 16'd0;
    logic fifo_full, bclk, fsync, sdata, err_flag;

    always #4 clk = ~clk;

    slot_audio_tx #(.DATA_W(DW), .SLOTS(NS), .FIFO_DEPTH(FD), .DIV_W(DVW)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en),
        .bclk_div(bclk_div), .word_len_m1(word_len_m1), .frame_len_m1(frame_len_m1),
        .slot_mask(slot_mask), .cont_on_err(cont_on_err), .err_clr(err_clr),
        .wr_valid(wr_valid), .wr_data(wr_data), .fifo_full(fifo_full),
        .bclk(bclk), .fsync(fsync), .sdata(sdata), .err_flag(err_flag)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, last_rise = 0, per_err = 0, st_err = 0, frm = -1;
    int mslot = 0, mbit = 0, sync_cnt = 0, first_delay = -1, en_cyc = 0;
    int cur_fl = 1, cur_wl = 16, cur_dv = 1, pidx = 0;
    bit rise_seen = 0, await_first = 0, prev_bclk = 0;
    logic [15:0] acc = 16'd0;
    logic [15:0] got [32][8];
    logic [15:0] pool [64];
    int refill_n [32];
    bit clr_at [32];

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock step; samples outputs at the falling edge and decodes the line
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (bclk && !prev_bclk) begin
            if (await_first) begin
                first_delay = cyc - en_cyc;
                await_first = 0;
            end
            if (rise_seen && (cyc - last_rise) != 2 * (cur_dv + 1)) per_err++;
            rise_seen = 1;
            last_rise = cyc;
            if (fsync) begin
                if (frm >= 0 && !(mslot == cur_fl && mbit == 0)) st_err++;
                if (sdata) st_err++;
                frm++;
                mslot = 0; mbit = 0; acc = '0;
                sync_cnt++;
            end else if (frm >= 0) begin
                if (mslot >= cur_fl) st_err++;
                else begin
                    acc = {acc[14:0], sdata};
                    mbit++;
                    if (mbit == cur_wl) begin
                        if (frm < 32) got[frm][mslot] = acc;
                        mslot++; mbit = 0; acc = '0;
                    end
                end
            end
        end
        prev_bclk = bclk;
    endtask

    task automatic push_word();
        pool[pidx] = 16'($urandom);
        wr_valid = 1'b1;
        wr_data  = pool[pidx];
        pidx++;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic clear_plan();
        for (int i = 0; i < 32; i++) begin
            refill_n[i] = 0;
            clr_at[i] = 0;
        end
    endtask

    task automatic run_case(input int fl, input int wl, input int dv, input logic [7:0] msk,
                            input bit cont, input int n_init, input int nfr,
                            input string req, input bit do_srst, input bit chk_full);
        int mq [64];
        int qh, qt, k, mode, eslot, mism, first_f, first_s, first_a, first_e;
        bit mflag;
        logic [15:0] wm, ev;
        if (do_srst) begin
            soft_rst = 1'b1; tick(); tick(); soft_rst = 1'b0; tick();
        end
        frame_len_m1 = 3'(fl); word_len_m1 = 4'(wl); bclk_div = DVW'(dv);
        slot_mask = msk; cont_on_err = cont;
        cur_fl = fl + 1; cur_wl = wl + 1; cur_dv = dv;
        pidx = 0;
        for (int i = 0; i < n_init; i++) push_word();
        if (chk_full) check(fifo_full == 1'b1, "R12", "fifo_full after overfill", int'(fifo_full), 1);
        // short enable with no bit end, then disable: the restart case
        tx_en = 1'b1; en_cyc = cyc; await_first = 1;
        repeat (dv + 2) tick();
        tx_en = 1'b0; tick(); tick();
        check(bclk == 1'b0, "R1", "bclk while disabled", int'(bclk), 0);
        frm = -1; mslot = 0; mbit = 0; sync_cnt = 0; per_err = 0; st_err = 0; rise_seen = 0;
        for (int f = 0; f < 32; f++)
            for (int s = 0; s < 8; s++) got[f][s] = 16'hDEAD;
        tx_en = 1'b1; en_cyc = cyc; await_first = 1; first_delay = -1;
        k = 0;
        while (sync_cnt < nfr + 1) begin
            tick();
            if (sync_cnt > k) begin
                k = sync_cnt;
                if (k - 1 < nfr) begin
                    err_clr = clr_at[k-1];
                    if (refill_n[k-1] == 0) tick();
                    else for (int r = 0; r < refill_n[k-1]; r++) begin
                        push_word();
                        err_clr = 1'b0;
                    end
                    err_clr = 1'b0;
                end
            end
        end
        tx_en = 1'b0; tick(); tick();
        check(first_delay == dv + 1, "R2", "first bclk rise after re-enable", first_delay, dv + 1);
        check(per_err == 0, "R1", "bclk period mismatches", per_err, 0);
        check(st_err == 0, "R3", "frame structure errors", st_err, 0);
        // frame-level reference
        wm = 16'((32'd1 << (wl + 1)) - 1);
        qh = 0; qt = 0; mode = 0; eslot = 0; mflag = 0; mism = 0;
        first_f = 0; first_s = 0; first_a = 0; first_e = 0;
        for (int i = 0; i < n_init; i++) if (qt - qh < FD) begin mq[qt] = i; qt++; end
        k = n_init;
        for (int f = 0; f < nfr; f++) begin
            for (int r = 0; r < refill_n[f]; r++) begin
                if (qt - qh < FD) begin mq[qt] = k; qt++; end
                k++;
            end
            if (clr_at[f]) mflag = 0;
            for (int s = 0; s <= fl; s++) begin
                ev = '0;
                if (!msk[s]) begin
                    if (mode == 0) begin
                        if (qt > qh) begin ev = pool[mq[qh]] & wm; qh++; end
                        else begin mflag = 1; eslot = s; mode = cont ? 1 : 2; end
                    end else if (mode == 1 && s == eslot) begin
                        if (qt > qh) begin ev = pool[mq[qh]] & wm; qh++; mode = 0; end
                        else mflag = 1;
                    end
                end
                if (got[f][s] !== ev) begin
                    if (mism == 0) begin
                        first_f = f; first_s = s; first_a = int'(got[f][s]); first_e = int'(ev);
                    end
                    mism++;
                end
            end
            if (mode == 2 && !mflag) mode = 0;
        end
        if (mism != 0) $display("  first mismatch frame %0d slot %0d", first_f, first_s);
        check(mism == 0, req, "slot word", first_a, first_e);
        check(err_flag == mflag, "R7", "err_flag after run", int'(err_flag), int'(mflag));
    endtask

    initial begin
        void'($urandom(32'h1d2c));
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        check(bclk == 0 && fsync == 0 && sdata == 0 && err_flag == 0 && fifo_full == 0,
              "R11", "outputs after reset", int'({bclk, fsync, sdata, err_flag, fifo_full}), 0);

        // R4 R5: plain frames, full words, MSB first
        clear_plan();
        run_case(3, 15, 2, 8'h00, 1'b0, 8, 2, "R4", 1'b1, 1'b0);
        // R6: masked slots quiet and not consuming
        clear_plan();
        run_case(5, 7, 1, 8'b0010_0101, 1'b0, 6, 2, "R6", 1'b1, 1'b0);
        // R8 R9: masked slots ahead of the underrun slot, recovery at that slot
        clear_plan();
        refill_n[2] = 2; refill_n[3] = 2; refill_n[4] = 2; clr_at[3] = 1;
        run_case(3, 7, 4, 8'b0000_0011, 1'b1, 3, 5, "R9", 1'b1, 1'b0);
        // R10: halt until cleared, restart at slot 0 of the following frame
        clear_plan();
        refill_n[1] = 3; clr_at[2] = 1;
        run_case(2, 5, 3, 8'h00, 1'b0, 2, 4, "R10", 1'b1, 1'b0);
        // R12: overfill, extra words dropped; frame 1 underruns (R8)
        clear_plan();
        run_case(7, 15, 1, 8'h00, 1'b1, 10, 2, "R12", 1'b1, 1'b1);
        // R11: soft reset flushes FIFO and clears the flag
        for (int i = 0; i < FD; i++) push_word();
        check(fifo_full == 1'b1, "R12", "fifo_full before soft reset", int'(fifo_full), 1);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0; tick();
        check(err_flag == 1'b0, "R11", "err_flag after soft reset", int'(err_flag), 0);
        check(fifo_full == 1'b0, "R11", "fifo_full after soft reset", int'(fifo_full), 0);
        clear_plan();
        run_case(1, 11, 2, 8'h00, 1'b1, 1, 2, "R11", 1'b0, 1'b0);

        // constrained random (R5 R7 R8 R10 under mixed settings)
        for (int t = 0; t < 8; t++) begin
            int fl, wl, dv, ni;
            clear_plan();
            fl = int'($urandom_range(7, 0));
            wl = int'($urandom_range(15, 3));
            dv = int'($urandom_range(4, 1));
            ni = int'($urandom_range(8, 0));
            for (int f = 0; f < 4; f++) begin
                refill_n[f] = int'($urandom_range(dv, 0));
                clr_at[f] = 1'($urandom_range(1, 0));
            end
            run_case(fl, wl, dv, 8'($urandom), 1'($urandom_range(1, 0)), ni, 4, "R5", 1'b1, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule